// File: doc/BRIEF.md
# Serial Transmitter with Holding Stage

This block turns bytes into asynchronous serial characters on a single output line. A byte offered with a write strobe lands in a one-entry holding stage. As soon as the shift engine is idle, that byte moves into the shift engine, which frees the holding stage for the next byte while the current character goes out. The character shape is chosen at run time: 5 to 8 data bits, one or two stop bits, and an optional parity bit. The parity bit can be odd, even, or held at a constant value.

The bit rate comes from an external tick that pulses at sixteen times the bit rate. Every bit on the line lasts sixteen such ticks. A break input pulls the line low at once, for as long as it stays asserted, and it does not disturb the shift engine's progress. Two status outputs tell the producer when it may write again and when the line has fully drained.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A write taken while the holding stage is empty clears `hold_empty` from the next cycle. `hold_empty` sets again one cycle after the byte moves into the shift engine. That move happens on the first clock edge at which the holding stage is full and the shift engine is idle.
- R3: `tx_empty` is 1 exactly when the holding stage is empty and the shift engine is idle.
- R4: A write offered while the holding stage is full is discarded. This includes the cycle in which the held byte moves into the shift engine. A discarded byte never appears on `txd`.
- R5: A character is sent in this order: a 0 start bit, the data bits least significant first, the parity bit if parity is enabled, then the stop bits at 1. Each bit lasts exactly 16 `tick16` pulses. The start bit begins in the cycle after the move.
- R6: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits above the selected length are not sent.
- R7: `two_stop` = 0 gives one stop bit and `two_stop` = 1 gives two.
- R8: With `par_en` = 1, `par_kind` selects the parity bit. 0 makes the count of ones in the data bits and parity bit odd, 1 makes that count even, 2 sends a constant 1, and 3 sends a constant 0. With `par_en` = 0 no parity bit is sent.
- R9: While `brk` is 1, `txd` is 0 in the same cycle. The shift engine keeps its timing, so the character resumes at its current position when `brk` falls.
- R10: The format inputs are sampled when a byte moves into the shift engine. Changing them during a character does not alter that character.
- R11: With no character in progress and `brk` at 0, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to send |
| len_sel | input | 2 | Data length select (5 + value bits) |
| two_stop | input | 1 | Stop-bit count select |
| par_en | input | 1 | Parity bit enable |
| par_kind | input | 2 | Parity kind: odd, even, constant 1, constant 0 |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding stage can take a byte |
| tx_empty | output | 1 | Holding stage and shift engine both empty |

## Verification
Two events can fall on the same clock edge: the holding stage handing its byte to an idle shift engine, and a new write strobe. The bench provokes this by holding `wr_en` high for two cycles in a row while the shift engine is idle. The first cycle fills the holding stage. The second coincides with the move into the shift engine, so that byte must be discarded. The behavioural reference model, stepped every clock, shows that only the first byte is framed on `txd` and that `hold_empty` sets afterwards. A second overlap puts `brk` on top of an active character. The model judges it by expecting 0 on the line while `brk` is high and an unbroken 16-tick bit schedule once `brk` is released.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [1:0] {
      PAR_ODD  = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ONE  = 2'd2,
      PAR_ZERO = 2'd3
   } par_kind_t;

   typedef struct packed {
      logic [1:0] len_sel;
      logic       two_stop;
      logic       par_en;
      par_kind_t  kind;
   } fmt_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] q
);
   logic accept;

   // A write is only taken into an empty stage; take only happens when full.
   assign accept = wr_en && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         q    <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (accept) begin
         full <= 1'b1;
         q    <= wr_data;
      end
   end
endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 4
) (
   input  logic [DATA_W-1:0] data,
   input  logic [LEN_W-1:0]  nbits,
   input  sertx_pkg::par_kind_t kind,
   output logic              par_bit
);
   import sertx_pkg::*;

   logic [DATA_W-1:0] masked;
   logic              ones_odd;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign masked[i] = data[i] & (LEN_W'(i) < nbits);
   end

   assign ones_odd = ^masked;

   always_comb begin
      unique case (kind)
         PAR_ODD:  par_bit = ~ones_odd;
         PAR_EVEN: par_bit = ones_odd;
         PAR_ONE:  par_bit = 1'b1;
         default:  par_bit = 1'b0;
      endcase
   end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int DATA_W  = 8,
   parameter int TICKS   = 16,
   parameter int MIN_LEN = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  sertx_pkg::fmt_t   fmt,
   output logic              busy,
   output logic              sdo,
   output logic [$clog2(TICKS)-1:0] tcnt_o
);
   import sertx_pkg::*;

   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int LEN_W   = $clog2(DATA_W + 1);
   localparam int TC_W    = $clog2(TICKS);

   logic [FRAME_W-1:0] frame_q, frame_new;
   logic [CNT_W-1:0]   left_q, count_new;
   logic [TC_W-1:0]    tcnt_q;
   logic [LEN_W-1:0]   nbits;
   logic               par_bit;
   logic               bit_end;

   assign nbits = LEN_W'(MIN_LEN) + LEN_W'(fmt.len_sel);

   sertx_parity #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_par (
      .data    (din),
      .nbits   (nbits),
      .kind    (fmt.kind),
      .par_bit (par_bit)
   );

   // Frame image: start at bit 0, data, optional parity; remaining bits are stop ones.
   always_comb begin
      frame_new    = '1;
      frame_new[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (LEN_W'(i) < nbits) frame_new[1+i] = din[i];
      end
      if (fmt.par_en) frame_new[1 + int'(nbits)] = par_bit;
      count_new = CNT_W'(2) + CNT_W'(nbits) + CNT_W'(fmt.par_en) + CNT_W'(fmt.two_stop);
   end

   if ((1 << TC_W) == TICKS) begin : g_wrap_pow2
      assign bit_end = &tcnt_q;
   end else begin : g_wrap_cmp
      assign bit_end = (tcnt_q == TC_W'(TICKS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '1;
         left_q  <= '0;
         tcnt_q  <= '0;
         busy    <= 1'b0;
      end else if (load) begin
         frame_q <= frame_new;
         left_q  <= count_new;
         tcnt_q  <= '0;
         busy    <= 1'b1;
      end else if (busy && tick) begin
         if (bit_end) begin
            tcnt_q  <= '0;
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            left_q  <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) busy <= 1'b0;
         end else begin
            tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   assign sdo    = frame_q[0];
   assign tcnt_o = tcnt_q;
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
   parameter int DATA_W = 8,
   parameter int TICKS  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        len_sel,
   input  logic              two_stop,
   input  logic              par_en,
   input  logic [1:0]        par_kind,
   input  logic              brk,
   output logic              txd,
   output logic              hold_empty,
   output logic              tx_empty
);
   import sertx_pkg::*;

   localparam int MIN_LEN = DATA_W - 3;
   localparam int TC_W    = $clog2(TICKS);

   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
      $error("sertx_top: DATA_W must lie in 5..16");
   end
   if (TICKS < 2) begin : g_bad_ticks
      $error("sertx_top: TICKS must be at least 2");
   end

   logic              hold_full;
   logic [DATA_W-1:0] hold_q;
   logic              sh_busy;
   logic              sh_sdo;
   logic              xfer;
   logic [TC_W-1:0]   sh_tcnt;
   fmt_t              fmt;

   assign fmt  = '{len_sel: len_sel, two_stop: two_stop, par_en: par_en,
                   kind: par_kind_t'(par_kind)};
   assign xfer = hold_full && !sh_busy;

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (xfer),
      .full    (hold_full),
      .q       (hold_q)
   );

   sertx_shift #(.DATA_W(DATA_W), .TICKS(TICKS), .MIN_LEN(MIN_LEN)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick16),
      .load   (xfer),
      .din    (hold_q),
      .fmt    (fmt),
      .busy   (sh_busy),
      .sdo    (sh_sdo),
      .tcnt_o (sh_tcnt)
   );

   assign txd        = brk ? 1'b0 : (sh_busy ? sh_sdo : 1'b1);
   assign hold_empty = !hold_full;
   assign tx_empty   = !hold_full && !sh_busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
   parameter int TC_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            brk,
   input logic            wr_en,
   input logic            txd,
   input logic            hold_empty,
   input logic            tx_empty,
   input logic            busy,
   input logic [TC_W-1:0] tcnt
);
   // R9: break overrides the line
   p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> !txd);

   // R11: drained line idles high
   p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && !brk) |-> txd);

   // R2: accepted write fills the holding stage
   p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_empty && wr_en) |=> !hold_empty);

   // R2: no move while the shift engine is busy
   p_hold_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_empty && busy) |=> !hold_empty);

   // R3: drained implies holding empty and engine idle
   p_empty_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> (hold_empty && !busy));

   // R5: a new character opens with a start bit at tick phase zero
   p_start_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !brk) |-> (!txd && tcnt == '0));

   // R5: the engine only starts from a full holding stage
   p_start_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!hold_empty));
endmodule

bind sertx_top sertx_chk #(.TC_W($clog2(TICKS))) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .brk        (brk),
   .wr_en      (wr_en),
   .txd        (txd),
   .hold_empty (hold_empty),
   .tx_empty   (tx_empty),
   .busy       (sh_busy),
   .tcnt       (sh_tcnt)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] len_sel = 2'd3;
   logic       two_stop = 1'b0;
   logic       par_en = 1'b0;
   logic [1:0] par_kind = 2'd0;
   logic       brk = 1'b0;
   logic       txd, hold_empty, tx_empty;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_req = "R5";
   int tick_div = 1;
   int tick_cnt = 0;

   always #4 clk = ~clk;   // 125 MHz

   sertx_top u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
      .len_sel(len_sel), .two_stop(two_stop), .par_en(par_en), .par_kind(par_kind),
      .brk(brk), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
   );

   // Tick generator, driven away from the active edge
   always @(negedge clk) begin
      tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
      tick16   = (tick_cnt == 0);
   end

   // Behavioural reference model
   bit m_hold, m_busy;
   logic [7:0] m_data;
   int m_tc;
   bit bits_q[$];

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hold = 0; m_busy = 0; m_tc = 0; bits_q.delete();
      end else begin
         bit acc, ld;
         acc = wr_en && !m_hold;
         ld  = m_hold && !m_busy;
         if (m_busy && tick16) begin
            m_tc++;
            if (m_tc == 16) begin
               m_tc = 0;
               void'(bits_q.pop_front());
               if (bits_q.size() == 0) m_busy = 0;
            end
         end
         if (ld) begin
            int n, ones;
            bit p;
            n = 5 + int'(len_sel);
            ones = 0;
            bits_q.push_back(1'b0);
            for (int i = 0; i < n; i++) begin
               bits_q.push_back(m_data[i]);
               ones += m_data[i];
            end
            if (par_en) begin
               case (par_kind)
                  2'd0: p = (ones % 2 == 0);
                  2'd1: p = (ones % 2 == 1);
                  2'd2: p = 1'b1;
                  default: p = 1'b0;
               endcase
               bits_q.push_back(p);
            end
            bits_q.push_back(1'b1);
            if (two_stop) bits_q.push_back(1'b1);
            m_busy = 1; m_tc = 0; m_hold = 0;
         end
         if (acc) begin
            m_hold = 1; m_data = wr_data;
         end
      end
      #2;
      if (rst_n && !done) begin
         logic exp_txd;
         exp_txd = brk ? 1'b0 : (m_busy ? bits_q[0] : 1'b1);
         check(brk ? "R9" : cur_req, txd, exp_txd);
         check("R2", hold_empty, !m_hold);
         check("R3", tx_empty, !m_hold && !m_busy);
      end
   end

   task automatic send(logic [7:0] d);
      while (!hold_empty) @(negedge clk);
      wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (!tx_empty) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check("R1", txd, 1'b1);
      check("R1", hold_empty, 1'b1);
      check("R1", tx_empty, 1'b1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5, R2: basic 8N1 character, second byte held while the first shifts
      cur_req = "R5";
      send(8'hA5);
      check("R2", hold_empty, 1'b0);
      send(8'h3C);
      // R4: writes while holding is full are discarded
      cur_req = "R4";
      wr_data = 8'hFF; wr_en = 1'b1;
      repeat (5) @(negedge clk);
      wr_en = 1'b0;
      drain();

      // R6: each character length, with slower ticks
      tick_div = 3;
      for (int l = 0; l < 4; l++) begin
         cur_req = "R6";
         len_sel = 2'(l);
         send(8'hB6);
         drain();
      end
      tick_div = 1;

      // R7: two stop bits, back-to-back characters
      cur_req = "R7";
      two_stop = 1'b1;
      send(8'h81); send(8'h7E);
      drain();
      two_stop = 1'b0;

      // R8: every parity kind, odd and even data weight
      par_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         cur_req = "R8";
         par_kind = 2'(k);
         send(8'h13); send(8'h17);
         drain();
      end

      // R10: format changed mid-character
      cur_req = "R10";
      par_kind = 2'd1; len_sel = 2'd3;
      send(8'hC9);
      repeat (20) @(negedge clk);
      par_en = 1'b0; len_sel = 2'd0; two_stop = 1'b1;
      drain();
      two_stop = 1'b0; len_sel = 2'd3;

      // R9: break during a character, then resume
      cur_req = "R9";
      send(8'h5A);
      repeat (30) @(negedge clk);
      brk = 1'b1;
      @(negedge clk);
      check("R9", txd, 1'b0);
      repeat (40) @(negedge clk);
      brk = 1'b0;
      cur_req = "R5";
      drain();

      // R4: write in the same cycle the held byte moves to the engine
      cur_req = "R4";
      wr_data = 8'h96; wr_en = 1'b1;
      @(negedge clk);
      wr_data = 8'h69;
      @(negedge clk);
      wr_en = 1'b0;
      check("R4", hold_empty, 1'b1);
      drain();

      // R11: drained line idles high
      check("R11", txd, 1'b1);
      check("R3", tx_empty, 1'b1);
      finish_run();
   end
endmodule